// File: doc/BRIEF.md
# Outstanding Memory Request Admission Table

This block decides whether a memory request from a processor core may be sent on to the cache controller, or must be turned away. Each request is reduced to its cache-line address. It is then checked against two small fully associative tables. One holds pending reads (loads and instruction fetches). The other holds pending write-class operations: stores, read-modify-write halves, linked loads, conditional stores, locked read-modify-write halves and flushes. Each table holds at most one entry per line. The same line may not be pending in both tables at once.

The answer comes back in the same cycle, as one of three codes. A request is refused as full when the outstanding count is at its cap or its table has no free slot. It is refused as aliased when it collides with pending work on the same line, or when the line is locked. Otherwise it is accepted and recorded. When a completion arrives for a line on the read or write completion port, the matching entry is freed. The completion returns the type and the cycle stamp stored at admission.

A completed locked read-modify-write read locks its line. While the line is locked, only a locked read-modify-write write to it is accepted. The lock is released when that write completes. Four wrapping counters record the alias events, split by the kind of request refused and the table it collided with.

Top module: `reqtab_admit`

## Requirements
- R1: The line address is `req_addr_i[ADDR_W-1:OFF_W]` (the same field is used on both completion ports). Two requests that differ only in the low OFF_W bits refer to the same line.
- R2: A valid request is answered full (`resp_o` = 1) when the outstanding count is at least MAX_OUT, or when its target table has all DEPTH slots in use. A request answered full changes neither the tables nor the alias counters.
- R3: While a line is locked, any request to it is answered aliased (`resp_o` = 2), unless its type is locked write (8). Such a refusal does not change the alias counters.
- R4: Types load (0) and instruction fetch (1) go to the read table. Types 2 to 9 go to the write table: store 2, rmw read 3, rmw write 4, linked load 5, conditional store 6, locked read 7, locked write 8, flush 9. A read-table entry completes only on the read port, and a write-table entry only on the write port.
- R5: A write-class request to a line pending in the read table is aliased, and `alias_st_ld_o` is incremented. If the line is pending only in the write table, the request is aliased and `alias_st_st_o` is incremented.
- R6: A read-class request to a line pending in the write table is aliased, and `alias_ld_st_o` is incremented. If the line is pending only in the read table, the request is aliased and `alias_ld_ld_o` is incremented.
- R7: A request that is neither full nor aliased is answered issued (`resp_o` = 3) and entered into its table. With no request, `resp_o` = 0.
- R8: A completion that hits raises `rd_done_o` or `wr_done_o` in the same cycle. It returns the stored type and the value `cycle_o` had in the admitting cycle, and it frees the entry.
- R9: A completion whose line is not pending in the table for its port raises `cmp_err_o` in that cycle and changes no state.
- R10: A completing locked read (7) locks its line from the next cycle on. A completing locked write (8) to the locked line releases the lock.
- R11: `outstanding_o` rises by one for each admission and falls by one for each hitting completion. Admission and completion in the same cycle net out.
- R12: A request is judged against the state before any completion in the same cycle. A request to a line that is completing in that cycle is therefore aliased.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_type_i | input | 4 | Request type code |
| req_addr_i | input | ADDR_W | Request byte address |
| resp_o | output | 2 | 0 idle, 1 full, 2 aliased, 3 issued |
| rd_cmp_valid_i | input | 1 | Read completion present |
| rd_cmp_addr_i | input | ADDR_W | Read completion address |
| wr_cmp_valid_i | input | 1 | Write completion present |
| wr_cmp_addr_i | input | ADDR_W | Write completion address |
| rd_done_o | output | 1 | Read completion matched an entry |
| rd_done_type_o | output | 4 | Type of the freed read entry |
| rd_done_stamp_o | output | STAMP_W | Admission stamp of the freed read entry |
| wr_done_o | output | 1 | Write completion matched an entry |
| wr_done_type_o | output | 4 | Type of the freed write entry |
| wr_done_stamp_o | output | STAMP_W | Admission stamp of the freed write entry |
| cmp_err_o | output | 1 | A completion matched no pending entry |
| outstanding_o | output | OCNT_W | Number of pending entries in both tables |
| cycle_o | output | STAMP_W | Free-running cycle stamp |
| alias_st_ld_o | output | STAT_W | Write-class requests refused because of a pending read |
| alias_st_st_o | output | STAT_W | Write-class requests refused because of a pending write |
| alias_ld_st_o | output | STAT_W | Read-class requests refused because of a pending write |
| alias_ld_ld_o | output | STAT_W | Read-class requests refused because of a pending read |

## Verification
A lost or stale table entry shows up within a cycle or two. A stale entry makes the next request to its line come back aliased instead of issued. A lost entry raises `cmp_err_o` on the completion that should have matched it, and `outstanding_o` drifts from the count the bench keeps. A wrong lock state shows up on the first request to the locked line after the lock change: a stuck lock refuses a plain load, and a missed lock lets one through. A wrong stored type or stamp is visible on the completion port in the very cycle the completion arrives.

// File: rtl/reqtab_pkg.sv
package reqtab_pkg;

  typedef enum logic [3:0] {
    RT_LOAD    = 4'd0,
    RT_IFETCH  = 4'd1,
    RT_STORE   = 4'd2,
    RT_RMW_RD  = 4'd3,
    RT_RMW_WR  = 4'd4,
    RT_LINK_LD = 4'd5,
    RT_COND_ST = 4'd6,
    RT_LOCK_RD = 4'd7,
    RT_LOCK_WR = 4'd8,
    RT_FLUSH   = 4'd9
  } req_type_e;

  typedef enum logic [1:0] {
    RS_IDLE   = 2'd0,
    RS_FULL   = 2'd1,
    RS_ALIAS  = 2'd2,
    RS_ISSUED = 2'd3
  } req_stat_e;

  // alias counter slots
  localparam int AL_ST_LD = 0;
  localparam int AL_ST_ST = 1;
  localparam int AL_LD_ST = 2;
  localparam int AL_LD_LD = 3;
  localparam int AL_NUM   = 4;

  function automatic logic is_read_kind(logic [3:0] t);
    return (t == RT_LOAD) || (t == RT_IFETCH);
  endfunction

endpackage

// File: rtl/reqtab_cam.sv
module reqtab_cam #(
  parameter int DEPTH   = 4,
  parameter int LINE_W  = 12,
  parameter int STAMP_W = 16,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LINE_W-1:0]  look_line_i,
  output logic               look_hit_o,
  output logic               full_o,
  input  logic               ins_i,
  input  logic [3:0]         ins_type_i,
  input  logic [STAMP_W-1:0] ins_stamp_i,
  input  logic               rem_i,
  input  logic [LINE_W-1:0]  rem_line_i,
  output logic               rem_hit_o,
  output logic [3:0]         rem_type_o,
  output logic [STAMP_W-1:0] rem_stamp_o,
  output logic [CNT_W-1:0]   used_o
);

  logic [DEPTH-1:0]   vld_q;
  logic [LINE_W-1:0]  line_q  [DEPTH];
  logic [3:0]         type_q  [DEPTH];
  logic [STAMP_W-1:0] stamp_q [DEPTH];

  logic [DEPTH-1:0] look_match, rem_match;
  logic [IDX_W-1:0] free_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_match
    assign look_match[g] = vld_q[g] && (line_q[g] == look_line_i);
    assign rem_match[g]  = vld_q[g] && (line_q[g] == rem_line_i);
  end

  assign look_hit_o = |look_match;
  assign rem_hit_o  = rem_i && (|rem_match);
  assign full_o     = &vld_q;

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!vld_q[i]) free_idx = IDX_W'(i);
  end

  always_comb begin
    rem_type_o  = '0;
    rem_stamp_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      rem_type_o  |= rem_match[i] ? type_q[i]  : '0;
      rem_stamp_o |= rem_match[i] ? stamp_q[i] : '0;
    end
  end

  always_comb begin
    used_o = '0;
    for (int i = 0; i < DEPTH; i++) used_o += CNT_W'(vld_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        line_q[i]  <= '0;
        type_q[i]  <= '0;
        stamp_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (rem_i && rem_match[i]) vld_q[i] <= 1'b0;
        if (ins_i && !full_o && (free_idx == IDX_W'(i))) begin
          vld_q[i]   <= 1'b1;
          line_q[i]  <= look_line_i;
          type_q[i]  <= ins_type_i;
          stamp_q[i] <= ins_stamp_i;
        end
      end
    end
  end

  // one entry per line
  assert_one_per_line_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(look_match) && $onehot0(rem_match));

  // insertion only into a free slot for a line not yet present
  assert_ins_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_i |-> (!full_o && !look_hit_o));

  assert_ins_lands_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_i && !rem_hit_o) |=> (used_o == $past(used_o) + 1'b1));

endmodule

// File: rtl/reqtab_lock.sv
module reqtab_lock #(
  parameter int LINE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [LINE_W-1:0] cmp_line_i,
  input  logic [LINE_W-1:0] chk_line_i,
  output logic              blocked_o
);

  logic              lk_vld_q;
  logic [LINE_W-1:0] lk_line_q;

  assign blocked_o = lk_vld_q && (lk_line_q == chk_line_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_vld_q  <= 1'b0;
      lk_line_q <= '0;
    end else if (set_i) begin
      lk_vld_q  <= 1'b1;
      lk_line_q <= cmp_line_i;
    end else if (clr_i && lk_vld_q && (lk_line_q == cmp_line_i)) begin
      lk_vld_q  <= 1'b0;
    end
  end

  assert_lock_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> (lk_vld_q && (lk_line_q == $past(cmp_line_i))));

  assert_lock_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_i && clr_i));

endmodule

// File: rtl/reqtab_stats.sv
module reqtab_stats #(
  parameter int STAT_W = 16,
  parameter int NUM    = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM-1:0]             inc_i,
  output logic [NUM-1:0][STAT_W-1:0] cnt_o
);

  for (genvar g = 0; g < NUM; g++) begin : g_cnt
    logic [STAT_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_q <= '0;
      else if (inc_i[g]) cnt_q <= cnt_q + 1'b1;
    end
    assign cnt_o[g] = cnt_q;
  end

  // a single request yields at most one alias event
  assert_one_event_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(inc_i));

endmodule

// File: rtl/reqtab_admit.sv
module reqtab_admit
  import reqtab_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int OFF_W   = 4,
  parameter int DEPTH   = 4,
  parameter int MAX_OUT = 6,
  parameter int STAMP_W = 16,
  parameter int STAT_W  = 16,
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int TCNT_W = $clog2(DEPTH + 1),
  localparam int OCNT_W = $clog2(MAX_OUT + 2 * DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [3:0]         req_type_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  output logic [1:0]         resp_o,
  input  logic               rd_cmp_valid_i,
  input  logic [ADDR_W-1:0]  rd_cmp_addr_i,
  input  logic               wr_cmp_valid_i,
  input  logic [ADDR_W-1:0]  wr_cmp_addr_i,
  output logic               rd_done_o,
  output logic [3:0]         rd_done_type_o,
  output logic [STAMP_W-1:0] rd_done_stamp_o,
  output logic               wr_done_o,
  output logic [3:0]         wr_done_type_o,
  output logic [STAMP_W-1:0] wr_done_stamp_o,
  output logic               cmp_err_o,
  output logic [OCNT_W-1:0]  outstanding_o,
  output logic [STAMP_W-1:0] cycle_o,
  output logic [STAT_W-1:0]  alias_st_ld_o,
  output logic [STAT_W-1:0]  alias_st_st_o,
  output logic [STAT_W-1:0]  alias_ld_st_o,
  output logic [STAT_W-1:0]  alias_ld_ld_o
);

  logic [LINE_W-1:0] req_line, rd_line, wr_line;
  assign req_line = req_addr_i[ADDR_W-1:OFF_W];
  assign rd_line  = rd_cmp_addr_i[ADDR_W-1:OFF_W];
  assign wr_line  = wr_cmp_addr_i[ADDR_W-1:OFF_W];

  logic unused_offsets;
  assign unused_offsets = ^{req_addr_i[OFF_W-1:0], rd_cmp_addr_i[OFF_W-1:0],
                            wr_cmp_addr_i[OFF_W-1:0]};

  logic [STAMP_W-1:0] cyc_q;
  logic [OCNT_W-1:0]  out_q;

  logic rd_hit, wr_hit, rd_full, wr_full, blocked;
  logic admit_rd, admit_wr;
  logic [AL_NUM-1:0] alias_inc;
  req_stat_e resp;
  logic [TCNT_W-1:0] rd_used, wr_used;

  reqtab_cam #(.DEPTH(DEPTH), .LINE_W(LINE_W), .STAMP_W(STAMP_W)) u_rd_tab (
    .clk_i, .rst_ni,
    .look_line_i (req_line),
    .look_hit_o  (rd_hit),
    .full_o      (rd_full),
    .ins_i       (admit_rd),
    .ins_type_i  (req_type_i),
    .ins_stamp_i (cyc_q),
    .rem_i       (rd_cmp_valid_i),
    .rem_line_i  (rd_line),
    .rem_hit_o   (rd_done_o),
    .rem_type_o  (rd_done_type_o),
    .rem_stamp_o (rd_done_stamp_o),
    .used_o      (rd_used)
  );

  reqtab_cam #(.DEPTH(DEPTH), .LINE_W(LINE_W), .STAMP_W(STAMP_W)) u_wr_tab (
    .clk_i, .rst_ni,
    .look_line_i (req_line),
    .look_hit_o  (wr_hit),
    .full_o      (wr_full),
    .ins_i       (admit_wr),
    .ins_type_i  (req_type_i),
    .ins_stamp_i (cyc_q),
    .rem_i       (wr_cmp_valid_i),
    .rem_line_i  (wr_line),
    .rem_hit_o   (wr_done_o),
    .rem_type_o  (wr_done_type_o),
    .rem_stamp_o (wr_done_stamp_o),
    .used_o      (wr_used)
  );

  logic lock_set, lock_clr;
  assign lock_set = wr_done_o && (wr_done_type_o == RT_LOCK_RD);
  assign lock_clr = wr_done_o && (wr_done_type_o == RT_LOCK_WR);

  reqtab_lock #(.LINE_W(LINE_W)) u_lock (
    .clk_i, .rst_ni,
    .set_i      (lock_set),
    .clr_i      (lock_clr),
    .cmp_line_i (wr_line),
    .chk_line_i (req_line),
    .blocked_o  (blocked)
  );

  logic [AL_NUM-1:0][STAT_W-1:0] alias_cnt;

  reqtab_stats #(.STAT_W(STAT_W), .NUM(AL_NUM)) u_stats (
    .clk_i, .rst_ni,
    .inc_i (alias_inc),
    .cnt_o (alias_cnt)
  );

  logic is_rd;
  assign is_rd = is_read_kind(req_type_i);

  // admission decision: capacity, then line lock, then table aliasing
  always_comb begin
    resp      = RS_IDLE;
    admit_rd  = 1'b0;
    admit_wr  = 1'b0;
    alias_inc = '0;
    if (req_valid_i) begin
      if ((out_q >= OCNT_W'(MAX_OUT)) || (is_rd ? rd_full : wr_full)) begin
        resp = RS_FULL;
      end else if (blocked && (req_type_i != RT_LOCK_WR)) begin
        resp = RS_ALIAS;
      end else if (is_rd) begin
        if (wr_hit) begin
          resp = RS_ALIAS;
          alias_inc[AL_LD_ST] = 1'b1;
        end else if (rd_hit) begin
          resp = RS_ALIAS;
          alias_inc[AL_LD_LD] = 1'b1;
        end else begin
          resp     = RS_ISSUED;
          admit_rd = 1'b1;
        end
      end else begin
        if (rd_hit) begin
          resp = RS_ALIAS;
          alias_inc[AL_ST_LD] = 1'b1;
        end else if (wr_hit) begin
          resp = RS_ALIAS;
          alias_inc[AL_ST_ST] = 1'b1;
        end else begin
          resp     = RS_ISSUED;
          admit_wr = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      out_q <= '0;
    end else begin
      cyc_q <= cyc_q + 1'b1;
      out_q <= out_q + OCNT_W'(admit_rd | admit_wr)
                     - OCNT_W'(rd_done_o) - OCNT_W'(wr_done_o);
    end
  end

  assign resp_o        = resp;
  assign cmp_err_o     = (rd_cmp_valid_i && !rd_done_o) || (wr_cmp_valid_i && !wr_done_o);
  assign outstanding_o = out_q;
  assign cycle_o       = cyc_q;
  assign alias_st_ld_o = alias_cnt[AL_ST_LD];
  assign alias_st_st_o = alias_cnt[AL_ST_ST];
  assign alias_ld_st_o = alias_cnt[AL_LD_ST];
  assign alias_ld_ld_o = alias_cnt[AL_LD_LD];

  assert_cap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_q <= OCNT_W'(MAX_OUT));

  assert_lock_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && blocked && (req_type_i != RT_LOCK_WR)) |-> (resp_o != RS_ISSUED));

  assert_rd_port_kind_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_o |-> is_read_kind(rd_done_type_o));

  assert_wr_port_kind_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done_o |-> !is_read_kind(wr_done_type_o));

  assert_count_match_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_q == OCNT_W'(rd_used) + OCNT_W'(wr_used));

  assert_no_cross_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_hit && wr_hit));

endmodule

// File: tb/reqtab_admit_bench.sv
module reqtab_admit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int OFF_W = 4;
  localparam int MAX_OUT = 6;

  localparam int R_IDLE = 0, R_FULL = 1, R_ALIAS = 2, R_ISSUED = 3;
  localparam int T_LD = 0, T_IF = 1, T_ST = 2, T_RMWR = 3, T_FL = 9;
  localparam int T_LKRD = 7, T_LKWR = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid, rd_v, wr_v;
  logic [3:0] req_type;
  logic [ADDR_W-1:0] req_addr, rd_a, wr_a;
  logic [1:0] resp;
  logic rd_done, wr_done, cmp_err;
  logic [3:0] rd_type, wr_type;
  logic [15:0] rd_stamp, wr_stamp, cycle;
  logic [3:0] outstanding;
  logic [15:0] a_sl, a_ss, a_ls, a_ll;

  int n_run = 0, n_fail = 0;
  int e_sl = 0, e_ss = 0, e_ls = 0, e_ll = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reqtab_admit u_reqtab_admit (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_type_i(req_type), .req_addr_i(req_addr),
    .resp_o(resp),
    .rd_cmp_valid_i(rd_v), .rd_cmp_addr_i(rd_a),
    .wr_cmp_valid_i(wr_v), .wr_cmp_addr_i(wr_a),
    .rd_done_o(rd_done), .rd_done_type_o(rd_type), .rd_done_stamp_o(rd_stamp),
    .wr_done_o(wr_done), .wr_done_type_o(wr_type), .wr_done_stamp_o(wr_stamp),
    .cmp_err_o(cmp_err), .outstanding_o(outstanding), .cycle_o(cycle),
    .alias_st_ld_o(a_sl), .alias_st_st_o(a_ss),
    .alias_ld_st_o(a_ls), .alias_ld_ld_o(a_ll)
  );

  function automatic logic [ADDR_W-1:0] mk(int line, int off);
    return ADDR_W'((line << OFF_W) | off);
  endfunction

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_inputs();
    req_valid = 0; req_type = 0; req_addr = 0;
    rd_v = 0; rd_a = 0; wr_v = 0; wr_a = 0;
  endtask

  task automatic drive(bit rv, int t, logic [ADDR_W-1:0] a,
                       bit cr, logic [ADDR_W-1:0] ca, bit cw, logic [ADDR_W-1:0] wa);
    @(negedge clk);
    req_valid = rv; req_type = 4'(t); req_addr = a;
    rd_v = cr; rd_a = ca; wr_v = cw; wr_a = wa;
    #1;
  endtask

  task automatic commit();
    @(posedge clk);
    #1;
    clear_inputs();
  endtask

  task automatic issue(int t, logic [ADDR_W-1:0] a, int exp, string req, output int stamp);
    drive(1, t, a, 0, '0, 0, '0);
    stamp = int'(cycle);
    check(req, int'(resp), exp);
    commit();
  endtask

  task automatic done_rd(logic [ADDR_W-1:0] a, int ex_t, int ex_s, string req);
    drive(0, 0, '0, 1, a, 0, '0);
    check(req, int'(rd_done), 1);
    check(req, int'(rd_type), ex_t);
    if (ex_s >= 0) check(req, int'(rd_stamp), ex_s);
    check(req, int'(cmp_err), 0);
    commit();
  endtask

  task automatic done_wr(logic [ADDR_W-1:0] a, int ex_t, int ex_s, string req);
    drive(0, 0, '0, 0, '0, 1, a);
    check(req, int'(wr_done), 1);
    check(req, int'(wr_type), ex_t);
    if (ex_s >= 0) check(req, int'(wr_stamp), ex_s);
    check(req, int'(cmp_err), 0);
    commit();
  endtask

  task automatic check_stats(string req);
    check({req, " st_ld"}, int'(a_sl), e_sl);
    check({req, " st_st"}, int'(a_ss), e_ss);
    check({req, " ld_st"}, int'(a_ls), e_ls);
    check({req, " ld_ld"}, int'(a_ll), e_ll);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R7 idle resp", int'(resp), R_IDLE);
    check("R11 reset count", int'(outstanding), 0);
    check("R9 reset err", int'(cmp_err), 0);
    check_stats("R5 reset");
  endtask

  task automatic t_routing();
    int s1, s2, s3;
    issue(T_LD, mk(1, 0), R_ISSUED, "R7 load", s1);
    issue(T_ST, mk(2, 0), R_ISSUED, "R7 store", s2);
    issue(T_IF, mk(3, 0), R_ISSUED, "R7 ifetch", s3);
    check("R11 three pending", int'(outstanding), 3);
    done_wr(mk(2, 0), T_ST, s2, "R4 R8 store on wr port");
    done_rd(mk(1, 0), T_LD, s1, "R4 R8 load on rd port");
    done_rd(mk(3, 0), T_IF, s3, "R4 R8 ifetch on rd port");
    check("R11 drained", int'(outstanding), 0);
    issue(T_FL, mk(4, 0), R_ISSUED, "R4 flush", s1);
    done_wr(mk(4, 0), T_FL, s1, "R4 flush on wr port");
    issue(T_RMWR, mk(4, 0), R_ISSUED, "R4 rmw read", s1);
    done_wr(mk(4, 0), T_RMWR, s1, "R4 rmw read on wr port");
  endtask

  task automatic t_alias();
    int s;
    issue(T_LD, mk(5, 1), R_ISSUED, "R1 load off1", s);
    issue(T_LD, mk(5, 9), R_ALIAS, "R1 R6 load same line", s); e_ll++;
    issue(T_ST, mk(5, 3), R_ALIAS, "R5 store on load", s); e_sl++;
    check_stats("R5 R6 after read pending");
    done_rd(mk(5, 15), T_LD, -1, "R1 complete via other offset");
    issue(T_ST, mk(5, 0), R_ISSUED, "R7 store after free", s);
    issue(T_IF, mk(5, 2), R_ALIAS, "R6 ifetch on store", s); e_ls++;
    issue(T_ST, mk(5, 4), R_ALIAS, "R5 store on store", s); e_ss++;
    check_stats("R5 R6 after write pending");
    done_wr(mk(5, 0), T_ST, -1, "R8 store done");
  endtask

  task automatic t_full();
    int s;
    for (int i = 0; i < 4; i++) issue(T_ST, mk(10 + i, 0), R_ISSUED, "R7 fill wr", s);
    issue(T_ST, mk(14, 0), R_FULL, "R2 wr table full", s);
    issue(T_ST, mk(10, 0), R_FULL, "R2 full before alias", s);
    issue(T_LD, mk(20, 0), R_ISSUED, "R7 ld a", s);
    issue(T_LD, mk(21, 0), R_ISSUED, "R7 ld b", s);
    check("R11 at cap", int'(outstanding), MAX_OUT);
    issue(T_LD, mk(22, 0), R_FULL, "R2 count cap", s);
    issue(T_LD, mk(20, 0), R_FULL, "R2 cap before alias", s);
    check_stats("R2 no counter change");
    check("R2 count unchanged", int'(outstanding), MAX_OUT);
    for (int i = 0; i < 4; i++) done_wr(mk(10 + i, 0), T_ST, -1, "R8 drain wr");
    done_rd(mk(20, 0), T_LD, -1, "R8 drain rd a");
    done_rd(mk(21, 0), T_LD, -1, "R8 drain rd b");
    check("R11 empty", int'(outstanding), 0);
  endtask

  task automatic t_lock();
    int s;
    issue(T_LKRD, mk(30, 0), R_ISSUED, "R7 locked read", s);
    done_wr(mk(30, 0), T_LKRD, s, "R10 locked read done");
    issue(T_LD, mk(30, 5), R_ALIAS, "R3 load on locked line", s);
    issue(T_ST, mk(30, 0), R_ALIAS, "R3 store on locked line", s);
    check_stats("R3 no counter change");
    issue(T_LD, mk(31, 0), R_ISSUED, "R3 other line free", s);
    issue(T_LKWR, mk(30, 0), R_ISSUED, "R3 locked write passes", s);
    done_wr(mk(30, 0), T_LKWR, s, "R10 locked write done");
    issue(T_LD, mk(30, 0), R_ISSUED, "R10 line unlocked", s);
    done_rd(mk(30, 0), T_LD, -1, "R8 drain");
    done_rd(mk(31, 0), T_LD, -1, "R8 drain");
  endtask

  task automatic t_err();
    int s;
    drive(0, 0, '0, 1, mk(50, 0), 0, '0);
    check("R9 rd miss err", int'(cmp_err), 1);
    check("R9 rd miss no done", int'(rd_done), 0);
    commit();
    check("R9 count unchanged", int'(outstanding), 0);
    issue(T_LD, mk(51, 0), R_ISSUED, "R7 load", s);
    drive(0, 0, '0, 0, '0, 1, mk(51, 0));
    check("R4 R9 load on wr port err", int'(cmp_err), 1);
    check("R4 no wr done", int'(wr_done), 0);
    commit();
    check("R9 entry kept", int'(outstanding), 1);
    done_rd(mk(51, 0), T_LD, s, "R9 entry still intact");
  endtask

  task automatic t_same_cycle();
    int s;
    issue(T_LD, mk(60, 0), R_ISSUED, "R7 load", s);
    drive(1, T_LD, mk(60, 0), 1, mk(60, 0), 0, '0);
    check("R12 request vs completing line", int'(resp), R_ALIAS);
    check("R12 completion hits", int'(rd_done), 1);
    commit(); e_ll++;
    check("R11 freed", int'(outstanding), 0);
    check_stats("R12 alias counted");
    issue(T_LD, mk(61, 0), R_ISSUED, "R7 load", s);
    drive(1, T_ST, mk(62, 0), 1, mk(61, 0), 0, '0);
    check("R11 admit with completion", int'(resp), R_ISSUED);
    commit();
    check("R11 net zero", int'(outstanding), 1);
    done_wr(mk(62, 0), T_ST, -1, "R8 drain");
    check("R11 final empty", int'(outstanding), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    clear_inputs();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_routing();
    t_alias();
    t_full();
    t_lock();
    t_err();
    t_same_cycle();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule